// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a 16-bit processor built around a single accumulator. Eight instructions are executed, each as a short series of one-cycle control states under a hardwired state machine: an instruction fetch followed by one to three execute states. The datapath has four registers: the program counter, an address-out register that drives the memory address bus, a data-in register that captures everything read from memory, and the accumulator. A five-function ALU feeds the accumulator.

Memory is external and byte addressed, and each instruction is one 16-bit word. The core presents an address, a two-bit operation code and write data. It expects read data back in the same cycle and captures it at the end of that cycle. The next instruction address is always prepared while the current instruction finishes. A negative branch first advances as if it were not taken and corrects the flow in one extra state only when it is taken. Only direct operand addressing is provided.

Top module: `acc_core`

## Requirements
- R1: While `rst` is high, `mem_op` is 00. After `rst` falls, the first clock edge clears the program counter. The second edge starts the first fetch, which is a read at address 0. The fetch that follows a one-cycle-execute instruction reads address 2.
- R2: An instruction word carries the operand field X in bits 9:0 and the opcode in bits 12:10. Opcode 000 inverts AC, 001 shifts AC right, 010 branches if AC is negative, 011 jumps, 100 stores AC, 101 loads AC, 110 ANDs into AC and 111 adds into AC.
- R3: Instructions are fetched from consecutive even byte addresses, which advance by 2. At every fetch the program counter already holds the fetch address plus 2.
- R4: `mem_op` uses 00 for idle, 01 for read and 10 for write, and never 11. Read data is taken in the cycle in which the read is presented.
- R5: Opcode 000 replaces AC with its bitwise inverse. Opcode 001 shifts AC right by one and puts 0 into bit 15.
- R6: Opcodes 110 and 111 combine AC with X zero-extended to 16 bits. The sum drops its carry-out, so FFFF + 3 gives 0002.
- R7: A load reads the word at byte address X into AC. A store writes AC to byte address X in a single write cycle, with `mem_wdata` equal to AC during that cycle.
- R8: A branch fetches from X next only if AC bit 15 is 1. Otherwise execution continues at the following instruction.
- R9: A jump makes the next fetch read address X and leaves the program counter at X+2. A jump to its own address fetches itself every 2 cycles.
- R10: The cycle count from one fetch to the next is 2 for opcodes 000, 001, 110, 111 and 011. It is 3 for a store, 4 for a load, 2 for a branch that is not taken and 3 for a branch that is taken.
- R11: Bit 15 of the instruction word has no effect on execution. Bits 14:13 are not decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Byte address to memory (address-out register) |
| mem_op | output | 2 | Memory operation: 00 idle, 01 read, 10 write |
| mem_wdata | output | 16 | Write data, the accumulator value |
| mem_rdata | input | 16 | Read data, valid in the cycle of the read |

## Verification
A corrupted control state or a wrong program counter shows up at the address bus no later than the next fetch. The read lands on an address other than the previous one plus 2, or on something other than the branch or jump target, or the gap between two fetches has the wrong length. The bench therefore times every fetch of a straight-line program relative to the first fetch. An accumulator error stays hidden until the next store, so each ALU function is followed quickly by a store whose memory word is then checked. A looping self-modifying program that sums even numbers covers taken branches, jumps and load/store chains for several loop bounds.

// File: rtl/acc_pkg.sv
package acc_pkg;

  // control state codes
  typedef enum logic [3:0] {
    ST_RST1  = 4'b0000,
    ST_RST2  = 4'b0001,
    ST_FETCH = 4'b0010,
    ST_AOPR  = 4'b0011,
    ST_SOPR  = 4'b0100,
    ST_STO1  = 4'b0101,
    ST_STO2  = 4'b0110,
    ST_LD1   = 4'b1000,
    ST_LD2   = 4'b1001,
    ST_LD3   = 4'b1010,
    ST_BRN1  = 4'b1011,
    ST_BRN2  = 4'b1100,
    ST_JMP   = 4'b1101
  } st_e;

  typedef enum logic [2:0] {
    ALU_PASS = 3'b000,
    ALU_NOTB = 3'b001,
    ALU_AND  = 3'b010,
    ALU_ADD  = 3'b011,
    ALU_SHRB = 3'b100
  } alu_e;

  typedef enum logic [1:0] {
    MEM_IDLE = 2'b00,
    MEM_RD   = 2'b01,
    MEM_WR   = 2'b10
  } mop_e;

  typedef enum logic [1:0] {
    PC_HOLD = 2'b00,
    PC_CLR  = 2'b01,
    PC_INC  = 2'b10,
    PC_JMP  = 2'b11
  } pcact_e;

  // control word from the sequencer to the datapath
  typedef struct packed {
    alu_e   alu;
    mop_e   mop;
    pcact_e pc;
    logic   ao_le;   // address-out register load
    logic   ao_x;    // 1: address-out takes X, 0: takes PC
    logic   di_le;   // data-in register load
    logic   ac_le;   // accumulator load
    logic   a_full;  // 1: A bus is whole data-in, 0: zero-extended X
  } ctl_t;

  // low three opcode bits (the decoded part)
  localparam logic [2:0] OP_COMP = 3'd0;
  localparam logic [2:0] OP_SHR  = 3'd1;
  localparam logic [2:0] OP_BRN  = 3'd2;
  localparam logic [2:0] OP_JMP  = 3'd3;
  localparam logic [2:0] OP_STO  = 3'd4;
  localparam logic [2:0] OP_LD   = 3'd5;
  localparam logic [2:0] OP_AND  = 3'd6;
  localparam logic [2:0] OP_ADD  = 3'd7;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_e              op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    unique case (op)
      ALU_PASS: y = a;
      ALU_NOTB: y = ~b;
      ALU_AND:  y = a & b;
      ALU_ADD:  y = a + b;          // carry-out dropped
      ALU_SHRB: y = b >> 1;         // zero into the top bit
      default:  y = a;
    endcase
  end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] bus_opc,   // opcode seen on the read data during fetch
  input  logic [2:0] held_opc,  // opcode held in the data-in register
  input  logic       ac_neg,
  output st_e        st,
  output ctl_t       ctl
);

  st_e st_q, st_d;

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_RST1;
    else     st_q <= st_d;
  end

  assign st = st_q;

  always_comb begin
    ctl  = '0;
    st_d = st_q;
    unique case (st_q)
      ST_RST1: begin
        ctl.pc = PC_CLR;
        st_d   = ST_RST2;
      end
      ST_RST2: begin
        ctl.ao_le = 1'b1;
        ctl.pc    = PC_INC;
        st_d      = ST_FETCH;
      end
      ST_FETCH: begin
        ctl.mop   = MEM_RD;
        ctl.di_le = 1'b1;
        unique case (bus_opc)
          OP_COMP, OP_SHR: st_d = ST_SOPR;
          OP_BRN:          st_d = ST_BRN1;
          OP_JMP:          st_d = ST_JMP;
          OP_STO:          st_d = ST_STO1;
          OP_LD:           st_d = ST_LD1;
          default:         st_d = ST_AOPR;
        endcase
      end
      ST_AOPR: begin
        ctl.alu   = (held_opc == OP_ADD) ? ALU_ADD : ALU_AND;
        ctl.ac_le = 1'b1;
        ctl.ao_le = 1'b1;
        ctl.pc    = PC_INC;
        st_d      = ST_FETCH;
      end
      ST_SOPR: begin
        ctl.alu   = (held_opc == OP_SHR) ? ALU_SHRB : ALU_NOTB;
        ctl.ac_le = 1'b1;
        ctl.ao_le = 1'b1;
        ctl.pc    = PC_INC;
        st_d      = ST_FETCH;
      end
      ST_STO1: begin
        ctl.ao_le = 1'b1;
        ctl.ao_x  = 1'b1;
        st_d      = ST_STO2;
      end
      ST_STO2: begin
        ctl.mop   = MEM_WR;
        ctl.ao_le = 1'b1;
        ctl.pc    = PC_INC;
        st_d      = ST_FETCH;
      end
      ST_LD1: begin
        ctl.ao_le = 1'b1;
        ctl.ao_x  = 1'b1;
        st_d      = ST_LD2;
      end
      ST_LD2: begin
        ctl.mop   = MEM_RD;
        ctl.di_le = 1'b1;
        st_d      = ST_LD3;
      end
      ST_LD3: begin
        ctl.alu    = ALU_PASS;
        ctl.a_full = 1'b1;
        ctl.ac_le  = 1'b1;
        ctl.ao_le  = 1'b1;
        ctl.pc     = PC_INC;
        st_d       = ST_FETCH;
      end
      ST_BRN1: begin
        // speculate not taken
        ctl.ao_le = 1'b1;
        ctl.pc    = PC_INC;
        st_d      = ac_neg ? ST_BRN2 : ST_FETCH;
      end
      ST_BRN2, ST_JMP: begin
        ctl.ao_le = 1'b1;
        ctl.ao_x  = 1'b1;
        ctl.pc    = PC_JMP;
        st_d      = ST_FETCH;
      end
      default: st_d = ST_RST1;
    endcase
  end

endmodule

// File: rtl/acc_dpath.sv
module acc_dpath
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int X_W    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] ao,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ac,
  output logic [X_W-1:0]    x_fld,
  output logic [2:0]        op_fld
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

  logic [DATA_W-1:0] di_q;
  logic [ADDR_W-1:0] x_addr;
  logic [DATA_W-1:0] a_bus;
  logic [DATA_W-1:0] alu_y;

  assign x_fld  = di_q[X_W-1:0];
  assign op_fld = di_q[X_W+2:X_W];
  assign x_addr = ADDR_W'(x_fld);
  assign a_bus  = ctl.a_full ? di_q : DATA_W'(x_fld);

  acc_alu #(.DATA_W(DATA_W)) alu_i (
    .op (ctl.alu),
    .a  (a_bus),
    .b  (ac),
    .y  (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= '0;
      ao   <= '0;
      di_q <= '0;
      ac   <= '0;
    end else begin
      unique case (ctl.pc)
        PC_CLR:  pc <= '0;
        PC_INC:  pc <= pc + STEP;
        PC_JMP:  pc <= x_addr + STEP;
        default: pc <= pc;
      endcase
      if (ctl.ao_le) ao   <= ctl.ao_x ? x_addr : pc;
      if (ctl.di_le) di_q <= rdata;
      if (ctl.ac_le) ac   <= alu_y;
    end
  end

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int X_W    = 10
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_op,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int OPC_LO = X_W;
  localparam int OPC_HI = X_W + 2;

  st_e               st_w;
  ctl_t              ctl_w;
  logic [ADDR_W-1:0] pc_w;
  logic [DATA_W-1:0] ac_w;
  logic [X_W-1:0]    x_w;
  logic [2:0]        op_w;
  logic              ac_neg;

  assign ac_neg = ac_w[DATA_W-1];

  acc_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .bus_opc  (mem_rdata[OPC_HI:OPC_LO]),
    .held_opc (op_w),
    .ac_neg   (ac_neg),
    .st       (st_w),
    .ctl      (ctl_w)
  );

  acc_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .X_W(X_W)) dp_i (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl_w),
    .rdata  (mem_rdata),
    .ao     (mem_addr),
    .pc     (pc_w),
    .ac     (ac_w),
    .x_fld  (x_w),
    .op_fld (op_w)
  );

  assign mem_op    = ctl_w.mop;
  assign mem_wdata = ac_w;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
  import acc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int X_W    = 10
) (
  input logic              clk,
  input logic              rst,
  input st_e               st,
  input logic [1:0]        mem_op,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] pc,
  input logic              ac_neg,
  input logic [X_W-1:0]    xf
);

  p_op_legal_r4: assert property (@(posedge clk) disable iff (rst)
    mem_op != 2'b11);

  p_fetch_pc_ahead_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FETCH) |-> (pc == mem_addr + ADDR_W'(2)));

  p_brn_taken_neg_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BRN2) |-> $past(ac_neg));

  p_short_exec_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SOPR || st == ST_AOPR || st == ST_JMP || st == ST_BRN2 ||
     st == ST_STO2 || st == ST_LD3) |=> (st == ST_FETCH));

  p_write_addr_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_op == 2'b10) |-> ($past(st) == ST_STO1 &&
                           mem_addr == {{(ADDR_W-X_W){1'b0}}, $past(xf)}));

  p_jump_target_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_JMP) |=> (mem_addr == {{(ADDR_W-X_W){1'b0}}, $past(xf)}));

endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W), .X_W(X_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .st       (st_w),
  .mem_op   (mem_op),
  .mem_addr (mem_addr),
  .pc       (pc_w),
  .ac_neg   (ac_neg),
  .xf       (x_w)
);

// File: tb/acc_core_tb_top.sv
module acc_core_tb_top;

  localparam int CLK_P   = 10;
  localparam int WD_CYC  = 100000;
  localparam int NRUNS   = 6;
  localparam int N_TAB   [NRUNS] = '{0, 1, 2, 7, 10, 16};
  localparam int EXP_TAB [NRUNS] = '{0, 0, 2, 12, 30, 72};

  localparam logic [2:0] C_COMP = 3'd0, C_SHR = 3'd1, C_BRN = 3'd2, C_JMP = 3'd3,
                         C_STO  = 3'd4, C_LD  = 3'd5, C_AND = 3'd6, C_ADD = 3'd7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  logic [1:0]  mem_op;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;

  logic        ld_en = 1'b0;
  logic [8:0]  ld_a  = '0;
  logic [15:0] ld_d  = '0;
  logic [15:0] mem_w [512];
  logic        mon_clr = 1'b1;
  logic        done = 1'b0;

  int total = 0;
  int bad   = 0;
  int cyc, wr_cnt, last26, prev26;
  int fc [32];

  initial forever #(CLK_P/2) clk = ~clk;

  acc_core dut_i (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_op    (mem_op),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  // behavioural memory: combinational read, write at the clock edge
  assign mem_rdata = mem_w[mem_addr[9:1]];
  always @(posedge clk) begin
    if (ld_en) mem_w[ld_a] <= ld_d;
    else if (mem_op == 2'b10) mem_w[mem_addr[9:1]] <= mem_wdata;
  end

  // bus monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (mon_clr) begin
      cyc = 0; wr_cnt = 0; last26 = -1; prev26 = -1;
      for (int i = 0; i < 32; i++) fc[i] = -1;
    end else begin
      cyc = cyc + 1;
      if (mem_op == 2'b10) wr_cnt = wr_cnt + 1;
      if (mem_op == 2'b01 && mem_addr < 16'd64) begin
        if (fc[mem_addr[5:1]] < 0) fc[mem_addr[5:1]] = cyc;
        if (mem_addr == 16'd26) begin prev26 = last26; last26 = cyc; end
      end
    end
  end

  function automatic logic [15:0] enc(input logic [2:0] op, input int x);
    return {3'b000, op, x[9:0]};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input int byte_a, input logic [15:0] d);
    @(posedge clk); #1;
    ld_en = 1'b1; ld_a = byte_a[9:1]; ld_d = d;
  endtask

  task automatic enter_reset();
    @(posedge clk); #1;
    rst = 1'b1; mon_clr = 1'b1;
    for (int i = 0; i < 512; i++) poke(2*i, 16'h0000);
  endtask

  task automatic leave_reset();
    @(posedge clk); #1;
    ld_en = 1'b0;
    @(posedge clk); #1;
    rst = 1'b0; mon_clr = 1'b0;
  endtask

  // even-number sum, self-modifying: word at 18 is "ADD c"
  task automatic load_sum(input int n);
    poke(0,  enc(C_AND, 0));
    poke(2,  enc(C_STO, 512));
    poke(4,  enc(C_LD,  18));
    poke(6,  enc(C_AND, 1023));
    poke(8,  enc(C_COMP, 0));
    poke(10, enc(C_ADD, 1));
    poke(12, enc(C_ADD, n));
    poke(14, enc(C_BRN, 30));
    poke(16, enc(C_LD,  512));
    poke(18, enc(C_ADD, 2));
    poke(20, enc(C_STO, 512));
    poke(22, enc(C_LD,  18));
    poke(24, enc(C_ADD, 2));
    poke(26, enc(C_STO, 18));
    poke(28, enc(C_JMP, 4));
    poke(30, enc(C_JMP, 30));
  endtask

  initial begin
    #1;
    // ---------- directed program: ALU corners, timing, reset ----------
    enter_reset();
    poke(0,  enc(C_COMP, 0));
    poke(2,  enc(C_SHR, 0));
    poke(4,  enc(C_STO, 600));
    poke(6,  enc(C_COMP, 0));
    poke(8,  enc(C_SHR, 0));
    poke(10, enc(C_STO, 602));
    poke(12, enc(C_LD,  604));
    poke(14, enc(C_ADD, 3));
    poke(16, enc(C_STO, 606));
    poke(18, enc(C_AND, 0));
    poke(20, enc(C_BRN, 40));
    poke(22, enc(C_ADD, 5) | 16'h8000);
    poke(24, enc(C_STO, 608));
    poke(26, enc(C_JMP, 26));
    poke(40, enc(C_AND, 0));
    poke(42, enc(C_ADD, 99));
    poke(44, enc(C_STO, 608));
    poke(46, enc(C_JMP, 46));
    poke(604, 16'hFFFF);
    @(negedge clk);
    chk("R1 idle op in reset", mem_op, 0);
    leave_reset();
    @(negedge clk); chk("R1 idle before pc clear", mem_op, 0);
    @(negedge clk); chk("R1 idle in second reset state", mem_op, 0);
    @(negedge clk); chk("R1 first fetch op", mem_op, 1);
    chk("R1 first fetch addr", mem_addr, 0);
    repeat (60) @(negedge clk);
    chk("R5 invert then shift zero-fills", mem_w[300], 16'h7FFF);
    chk("R5 shift of negative value", mem_w[301], 16'h4000);
    chk("R6 add drops carry", mem_w[303], 16'h0002);
    chk("R8 R11 untaken branch, I bit ignored", mem_w[304], 16'h0005);
    chk("R4 write count", wr_cnt, 4);
    chk("R1 R3 second fetch at addr 2 after 2 cycles", fc[1] - fc[0], 2);
    chk("R7 R10 store takes 3 cycles", fc[3] - fc[2], 3);
    chk("R7 R10 load takes 4 cycles", fc[7] - fc[6], 4);
    chk("R8 R10 untaken branch 2 cycles", fc[11] - fc[10], 2);
    chk("R2 R10 straight-line timing to jump", fc[13] - fc[0], 32);
    chk("R9 self jump refetch period", last26 - prev26, 2);
    chk("R8 target never fetched", fc[20], -1);

    // ---------- table of loop bounds walked by one loop ----------
    for (int r = 0; r < NRUNS; r++) begin
      enter_reset();
      load_sum(N_TAB[r]);
      leave_reset();
      repeat (1500) @(negedge clk);
      chk($sformatf("R7 R8 R9 even sum for N=%0d", N_TAB[r]),
          mem_w[256], EXP_TAB[r]);
      chk($sformatf("R3 R9 parked at end for N=%0d", N_TAB[r]),
          mem_addr, 30);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d cycles", WD_CYC, WD_CYC);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule